// File: doc/BRIEF.md
# Shared Address/Data Parallel Port Controller

This block is the master side of an external parallel bus. One set of 16 bidirectional pads carries a 24-bit address and 8-bit or 16-bit data, one after the other. A strobe marks the address phase. Each transfer comes in as one request that holds an address, write data, a width flag and a read/write flag. The sequencer runs three named states. `ST_IDLE` waits for a request. `ST_ADDR` holds the strobe high for one cycle while the pads carry the address. `ST_DATA` holds the strobe low for a programmable number of cycles, during which write data is driven or read data is captured. Two transitions return the sequencer to `ST_IDLE`: one when the data phase runs out, and one that never leaves it while the port is switched off.

In byte mode the address cannot fit in one phase. The two upper address bytes go out with the strobe. The low address byte then stays on the upper pad half for the whole data phase, beside the data byte. In word mode the lower 16 address bits go out with the strobe, and all 16 pads carry data afterwards.

A port-off control hands every pad to a general-purpose flag block. Four group-enable bits do the same for single groups of four flags. Pads and flags are linked with the two bytes exchanged. The flag block supplies a direction and an output value for each flag, and it always sees the pad inputs.

Top module: `mux_ad_port`

## Requirements
- R1: After reset the sequencer is in `ST_IDLE`. `ale`, `busy`, `done` and `rd_data` are 0. No pad is driven by the port.
- R2: An accepted request moves `ST_IDLE`→`ST_ADDR`. `ale` is high for exactly one cycle, and all pads are driven. In byte mode (`req_wide`=0), `ad_out[7:0]`=A15..A8 and `ad_out[15:8]`=A23..A16.
- R3: In word mode (`req_wide`=1), `ad_out[15:0]`=A15..A0 during `ST_ADDR`.
- R4: During a byte-mode write in `ST_DATA`, `ad_out[7:0]`=D7..D0 and `ad_out[15:8]`=A7..A0, with all pads driven.
- R5: During a word-mode write in `ST_DATA`, `ad_out[15:0]`=D15..D0, with all pads driven.
- R6: `ST_DATA` lasts `cfg_wait`+1 cycles with `ale` low. `cfg_wait` is sampled when the request is accepted.
- R7: During a read in `ST_DATA`, the data pads are released. For a word read that is all 16 pads. For a byte read it is pads 7..0, while pads 15..8 keep driving A7..A0. The pads are sampled on the last data cycle. `rd_data` shows `ad_in` for a word read, and {8'h00, `ad_in[7:0]`} for a byte read, from the `done` cycle until the next read completes.
- R8: `done` is a one-cycle pulse in the first `ST_IDLE` cycle after `ST_DATA`. `busy` is high in `ST_ADDR` and `ST_DATA`.
- R9: A request is accepted only at a clock edge where `busy` is low. A request held while `busy` is high is neither lost nor altered, and it runs once `busy` falls.
- R10: While `cfg_port_off`=1, `busy` is high, no transfer starts, and every pad follows the flag block.
- R11: Pad p belongs to flag p+8 for p<8, and to flag p−8 for p≥8. A flag-owned pad has `ad_oe[p]`=`flag_dir[f]` and `ad_out[p]`=`flag_out[f]`. `flag_in[f]`=`ad_in[p]` at all times.
- R12: `cfg_flag_grp[g]`=1 gives flags 4g..4g+3, and their pads, to the flag block even while the port is on. The other pads keep their port function.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request, held until accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit data, 0 = 8-bit data |
| req_addr | input | 24 | Transfer address |
| req_wdata | input | 16 | Write data (low byte used in byte mode) |
| cfg_wait | input | 4 | Extra data-phase cycles |
| cfg_port_off | input | 1 | Hands all pads to the flag block |
| cfg_flag_grp | input | 4 | Per-group flag ownership |
| flag_dir | input | 16 | Flag output enables |
| flag_out | input | 16 | Flag output values |
| flag_in | output | 16 | Flag input values |
| ad_in | input | 16 | Pad input values |
| ad_out | output | 16 | Pad output values |
| ad_oe | output | 16 | Pad output enables |
| ale | output | 1 | Address strobe |
| busy | output | 1 | Request cannot be accepted |
| done | output | 1 | Transfer finished pulse |
| rd_data | output | 16 | Last read result |

## Verification
The assertions check on every cycle the properties that follow from state alone. The strobe is never high twice in a row. The done pulse lasts one cycle and always follows the data phase. Nothing starts while the port is off. A word read never drives the pads. Whether the right address byte lands on the right pad half, that the data phase has the right length, that read data is captured on the right cycle, and that a held request comes out unchanged are shown only by the bench scenarios. There, a behavioural model of each pad is compared with the block on every clock.

// File: rtl/ad_port_pkg.sv
package ad_port_pkg;
    localparam int unsigned AD_W   = 16;
    localparam int unsigned ADDR_W = 24;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA
    } seq_state_t;

    typedef struct packed {
        logic              write;
        logic              wide;
        logic [ADDR_W-1:0] addr;
        logic [AD_W-1:0]   wdata;
    } xfer_t;

    // pad index to flag index, bytes exchanged
    function automatic int unsigned flag_of_pad(int unsigned p, int unsigned half);
        return (p < half) ? p + half : p - half;
    endfunction
endpackage

// File: rtl/ad_seq.sv
module ad_seq
    import ad_port_pkg::*;
#(
    parameter int unsigned WAIT_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  xfer_t               req,
    input  logic [WAIT_W-1:0]   cfg_wait,
    input  logic                port_off,
    input  logic [AD_W-1:0]     pad_in,
    output seq_state_t          st,
    output xfer_t               cur,
    output logic                ale,
    output logic                busy,
    output logic                done,
    output logic [AD_W-1:0]     rd_data
);
    localparam int unsigned HALF = AD_W / 2;

    seq_state_t        st_nx;
    logic [WAIT_W-1:0] cnt;
    logic [WAIT_W-1:0] wait_l;
    logic              take;
    logic              last;

    assign take = req_valid && !port_off;
    assign last = (cnt == '0);

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (take) st_nx = ST_ADDR;
            ST_ADDR: st_nx = ST_DATA;
            ST_DATA: if (last) st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            wait_l  <= '0;
            cur     <= '0;
            done    <= 1'b0;
            rd_data <= '0;
        end else begin
            st   <= st_nx;
            done <= 1'b0;
            unique case (st)
                ST_IDLE: if (take) begin
                    cur    <= req;
                    wait_l <= cfg_wait;
                end
                ST_ADDR: cnt <= wait_l;
                ST_DATA: begin
                    if (last) begin
                        done <= 1'b1;
                        if (!cur.write)
                            rd_data <= cur.wide ? pad_in
                                                : {{HALF{1'b0}}, pad_in[HALF-1:0]};
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        ale  = (st == ST_ADDR);
        busy = (st != ST_IDLE) || port_off;
    end

    // R2
    ale_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    done_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(st) == ST_DATA) && (st == ST_IDLE));
    // R6
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA && cnt != '0) |=> (st == ST_DATA) && !ale);
    // R10
    port_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_off && st == ST_IDLE) |=> (st == ST_IDLE));
endmodule

// File: rtl/ad_lanes.sv
module ad_lanes
    import ad_port_pkg::*;
(
    input  seq_state_t      st,
    input  xfer_t           cur,
    output logic [AD_W-1:0] drv,
    output logic [AD_W-1:0] drv_oe
);
    localparam int unsigned HALF = AD_W / 2;

    always_comb begin
        drv    = '0;
        drv_oe = '0;
        unique case (st)
            ST_IDLE: ;
            ST_ADDR: begin
                drv_oe = '1;
                if (cur.wide) drv = cur.addr[AD_W-1:0];
                else          drv = cur.addr[ADDR_W-1:HALF];
            end
            ST_DATA: begin
                if (cur.wide) begin
                    drv    = cur.wdata;
                    drv_oe = cur.write ? '1 : '0;
                end else begin
                    drv    = {cur.addr[HALF-1:0], cur.wdata[HALF-1:0]};
                    drv_oe = {{HALF{1'b1}}, {HALF{cur.write}}};
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ad_pinsel.sv
module ad_pinsel
    import ad_port_pkg::*;
#(
    parameter int unsigned GRP_SZ = 4
) (
    input  logic                     port_off,
    input  logic [AD_W/GRP_SZ-1:0]   grp_en,
    input  logic [AD_W-1:0]          drv,
    input  logic [AD_W-1:0]          drv_oe,
    input  logic [AD_W-1:0]          flag_dir,
    input  logic [AD_W-1:0]          flag_out,
    input  logic [AD_W-1:0]          ad_in,
    output logic [AD_W-1:0]          flag_in,
    output logic [AD_W-1:0]          ad_out,
    output logic [AD_W-1:0]          ad_oe
);
    localparam int unsigned HALF = AD_W / 2;

    for (genvar p = 0; p < AD_W; p++) begin : g_pad
        localparam int unsigned F = flag_of_pad(p, HALF);
        logic own;
        assign own        = port_off | grp_en[F / GRP_SZ];
        assign ad_out[p]  = own ? flag_out[F] : drv[p];
        assign ad_oe[p]   = own ? flag_dir[F] : drv_oe[p];
        assign flag_in[F] = ad_in[p];
    end
endmodule

// File: rtl/mux_ad_port.sv
module mux_ad_port
    import ad_port_pkg::*;
#(
    parameter int unsigned WAIT_W = 4,
    parameter int unsigned GRP_SZ = 4,
    localparam int unsigned NGRP  = AD_W / GRP_SZ
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [AD_W-1:0]   req_wdata,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic              cfg_port_off,
    input  logic [NGRP-1:0]   cfg_flag_grp,
    input  logic [AD_W-1:0]   flag_dir,
    input  logic [AD_W-1:0]   flag_out,
    output logic [AD_W-1:0]   flag_in,
    input  logic [AD_W-1:0]   ad_in,
    output logic [AD_W-1:0]   ad_out,
    output logic [AD_W-1:0]   ad_oe,
    output logic              ale,
    output logic              busy,
    output logic              done,
    output logic [AD_W-1:0]   rd_data
);
    xfer_t           req;
    xfer_t           cur;
    seq_state_t      st;
    logic [AD_W-1:0] drv;
    logic [AD_W-1:0] drv_oe;

    assign req = '{write: req_write, wide: req_wide, addr: req_addr, wdata: req_wdata};

    ad_seq #(.WAIT_W(WAIT_W)) i_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req(req),
        .cfg_wait(cfg_wait), .port_off(cfg_port_off), .pad_in(ad_in),
        .st(st), .cur(cur), .ale(ale), .busy(busy), .done(done), .rd_data(rd_data)
    );

    ad_lanes i_lanes (
        .st(st), .cur(cur), .drv(drv), .drv_oe(drv_oe)
    );

    ad_pinsel #(.GRP_SZ(GRP_SZ)) i_pinsel (
        .port_off(cfg_port_off), .grp_en(cfg_flag_grp), .drv(drv), .drv_oe(drv_oe),
        .flag_dir(flag_dir), .flag_out(flag_out), .ad_in(ad_in),
        .flag_in(flag_in), .ad_out(ad_out), .ad_oe(ad_oe)
    );

    // R7
    word_read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA && !cur.write && cur.wide && !cfg_port_off && cfg_flag_grp == '0)
        |-> (ad_oe == '0));
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cfg_flag_grp == '0) |-> (ad_oe == '0) && !ale);
endmodule

// File: tb/test_mux_ad_port.sv
module test_mux_ad_port;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [3:0]  cfg_wait = '0;
    logic        cfg_port_off = 1'b0;
    logic [3:0]  cfg_flag_grp = '0;
    logic [15:0] flag_dir = '0, flag_out = '0, ad_in = '0;
    logic [15:0] flag_in, ad_out, ad_oe, rd_data;
    logic        ale, busy, done;

    int checks = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mux_ad_port i_mux_ad_port (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_wait(cfg_wait), .cfg_port_off(cfg_port_off), .cfg_flag_grp(cfg_flag_grp),
        .flag_dir(flag_dir), .flag_out(flag_out), .flag_in(flag_in), .ad_in(ad_in),
        .ad_out(ad_out), .ad_oe(ad_oe), .ale(ale), .busy(busy), .done(done),
        .rd_data(rd_data)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // behavioural model
    int          mph = 0;
    int          mcnt = 0, mwait = 0;
    logic        mw = 0, mwide = 0, mdone = 0, started = 0;
    logic [23:0] ma = '0;
    logic [15:0] md = '0, mrd = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mph = 0; mdone = 0; mrd = '0;
        end else begin
            mdone = 0;
            if (mph == 0) begin
                if (req_valid && !cfg_port_off) begin
                    mw = req_write; mwide = req_wide; ma = req_addr; md = req_wdata;
                    mwait = int'(cfg_wait); mph = 1;
                end
            end else if (mph == 1) begin
                mph = 2; mcnt = mwait;
            end else begin
                if (mcnt == 0) begin
                    mph = 0; mdone = 1;
                    if (!mw) mrd = mwide ? ad_in : {8'h00, ad_in[7:0]};
                end else mcnt--;
            end
        end
        started = 1;
    end

    always @(negedge clk) begin
        if (started) begin
            for (int p = 0; p < 16; p++) begin
                int f;
                logic own, eo, ev;
                string tag;
                f   = (p < 8) ? p + 8 : p - 8;
                own = cfg_port_off | cfg_flag_grp[f/4];
                eo = 0; ev = 0;
                if (own) begin
                    eo = flag_dir[f]; ev = flag_out[f];
                    tag = cfg_port_off ? "R10" : "R12";
                end else if (mph == 1) begin
                    eo = 1;
                    ev = mwide ? ma[p] : ma[p+8];
                    tag = mwide ? "R3" : "R2";
                end else if (mph == 2) begin
                    if (mwide) begin
                        eo = mw; ev = md[p];
                    end else if (p >= 8) begin
                        eo = 1; ev = ma[p-8];
                    end else begin
                        eo = mw; ev = md[p];
                    end
                    tag = !mw ? "R7" : (mwide ? "R5" : "R4");
                end else tag = "R1";
                chk(tag, $sformatf("oe[%0d]", p), 32'(ad_oe[p]), 32'(eo));
                if (eo) chk(tag, $sformatf("out[%0d]", p), 32'(ad_out[p]), 32'(ev));
            end
            chk(mph == 2 ? "R6" : "R2", "ale", 32'(ale), 32'(mph == 1));
            chk(cfg_port_off ? "R10" : (req_valid ? "R9" : "R8"), "busy",
                32'(busy), 32'((mph != 0) || cfg_port_off));
            chk("R8", "done", 32'(done), 32'(mdone));
            chk("R7", "rd_data", 32'(rd_data), 32'(mrd));
            chk("R11", "flag_in", 32'(flag_in), 32'({ad_in[7:0], ad_in[15:8]}));
        end
    end

    // present a request and hold it until accepted (R9)
    task automatic issue(logic w, logic wd, logic [23:0] a, logic [15:0] d, logic [3:0] ws);
        @(negedge clk);
        req_valid = 1; req_write = w; req_wide = wd; req_addr = a; req_wdata = d; cfg_wait = ws;
        while (busy) @(negedge clk);
        @(negedge clk);
        req_valid = 0; req_addr = 24'hFFFFFF; req_wdata = 16'hFFFF; cfg_wait = 4'hF;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy && !cfg_port_off);
        repeat (2) @(negedge clk);
    endtask

    task automatic report();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "reset busy", 32'(busy), 32'(0));
        chk("R1", "reset oe", 32'(ad_oe), 32'(0));
        rst_n = 1;
        repeat (2) @(negedge clk);
        // R2 R4 byte write
        issue(1, 0, 24'hA1B2C3, 16'h775D, 4'd2);  wait_idle();
        // R3 R5 word write, shortest data phase
        issue(1, 1, 24'h123456, 16'hBEEF, 4'd0);  wait_idle();
        // R7 byte read
        ad_in = 16'h7E96;
        issue(0, 0, 24'h0F1E2D, 16'h0000, 4'd3);  wait_idle();
        chk("R7", "byte read", 32'(rd_data), 32'h0096);
        // R7 word read
        ad_in = 16'hC35A;
        issue(0, 1, 24'h00ABCD, 16'h0000, 4'd1);  wait_idle();
        chk("R7", "word read", 32'(rd_data), 32'hC35A);
        // R9 second request held while first runs
        issue(1, 1, 24'h111111, 16'h2222, 4'd4);
        issue(1, 0, 24'h333333, 16'h0044, 4'd1);  wait_idle();
        // R10 R11 port off
        cfg_port_off = 1; flag_dir = 16'hF0F0; flag_out = 16'h1234; ad_in = 16'hABCD;
        @(negedge clk);
        req_valid = 1; req_write = 1; req_wide = 1; req_addr = 24'h555555; req_wdata = 16'h6666;
        repeat (4) @(negedge clk);
        chk("R11", "flag_in swap", 32'(flag_in), 32'hCDAB);
        chk("R10", "no strobe", 32'(ale), 32'(0));
        cfg_port_off = 0;
        repeat (2) @(negedge clk);
        req_valid = 0;
        wait_idle();
        // R12 one flag group owns pads 12..15
        cfg_flag_grp = 4'b0010; flag_dir = 16'h00F0; flag_out = 16'h00A0;
        issue(1, 1, 24'h9ABCDE, 16'h0F0F, 4'd2);  wait_idle();
        cfg_flag_grp = 4'b1001;
        issue(0, 0, 24'h13579B, 16'h0000, 4'd1);  wait_idle();
        repeat (3) @(negedge clk);
        report();
    end
endmodule